// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers and the status registers of a 32-bit RISC core that runs in several privilege modes. The program sees sixteen registers, numbered 0 to 15. Some privileged modes replace a few of those numbers with private copies. The block gives the core two combinational read ports and one write port, all addressed by the visible register number. The block itself works out which physical copy a number refers to in the active mode.

A mode-change request takes effect on one clock edge. After that edge the new mode's copies and its saved status register are the ones in view, and the previous mode's copies stay intact for its next entry.

The current status register holds two interrupt masks, a state bit and the mode field. The core writes the non-mode part of this register through its own port. The mode field changes only through a request.

Top module: `banked_regfile`

## Requirements
- R1: While reset is low and after it is released, the mode field reads 10000b-style encoding 10011 (supervisor), the status output is 0x000000D3, every register reads 0 and the saved status reads 0. In the status register, bit 7 is the normal-interrupt mask, bit 6 is the fast-interrupt mask, bit 5 is the state bit (0 selects 32-bit instructions) and bits 4:0 are the mode field.
- R2: Both read ports return the addressed register of the active mode combinationally and independently. A write is seen from the cycle after its edge, so a read in the write cycle returns the old value.
- R3: Registers 0 to 7 and register 15 are single copies that all modes share.
- R4: Fast-interrupt mode (10001) has private copies of registers 8 to 14. The values that registers 8 to 12 hold outside that mode are unaffected by it and reappear when it is left.
- R5: Supervisor (10011), abort (10111), normal-interrupt (10010) and undefined (11011) modes each have private copies of registers 13 and 14 only. Registers 8 to 12 are shared with user mode.
- R6: User (10000) and system (11111) modes share one copy of registers 13 and 14.
- R7: Each of the five privileged modes has its own saved status register. A value written in a mode is returned again whenever that mode is re-entered.
- R8: In user and system modes the saved status reads 0, and writes to it are ignored.
- R9: A request whose target is not one of the seven encodings is rejected and leaves all state unchanged. A request for the mode already active also changes nothing.
- R10: An accepted request switches the register view and the mode field on one edge. A register or saved-status write in that same cycle lands in the outgoing mode's copy.
- R11: A status write updates bits 31:5 only. The mode field changes only through a mode request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| stat_we | input | 1 | Status write enable (bits 31:5) |
| stat_wdata | input | 32 | Status write data |
| spsr_we | input | 1 | Saved status write enable |
| spsr_wdata | input | 32 | Saved status write data |
| spsr_rdata | output | 32 | Saved status of the active mode |
| mode_req | input | 1 | Mode change request |
| mode_tgt | input | 5 | Requested mode encoding |
| cur_mode | output | 5 | Active mode field |
| status | output | 32 | Current status register |

## Verification
The hardest case to reach is a write that lands in the same cycle as a mode change, especially on the way into or out of fast-interrupt mode. In that case the written value must end up in the outgoing copy, and it must not leak into registers 8 to 12 of the incoming view. The directed part of the stimulus drives exactly these edges and then reads the affected registers back after a round trip through the other mode. A long pseudo-random phase follows, in which mode requests (including invalid encodings) are mixed with writes and reads on every cycle. A swap-style reference model in the bench is compared against all outputs on every clock.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
   localparam int MODE_W    = 5;
   localparam int NUM_BANKS = 6;   // common + five privileged
   localparam int ST_IMASK  = 7;
   localparam int ST_FMASK  = 6;
   localparam int ST_STATE  = 5;

   typedef enum logic [MODE_W-1:0] {
      MD_USR = 5'b10000,
      MD_FIQ = 5'b10001,
      MD_IRQ = 5'b10010,
      MD_SVC = 5'b10011,
      MD_ABT = 5'b10111,
      MD_UND = 5'b11011,
      MD_SYS = 5'b11111
   } mode_e;

   localparam logic [2:0] BK_COMMON = 3'd0;
   localparam logic [2:0] BK_FIQ    = 3'd1;

   function automatic logic mode_ok(input logic [MODE_W-1:0] m);
      case (m)
         MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [2:0] bank_of(input logic [MODE_W-1:0] m);
      case (m)
         MD_FIQ:  return 3'd1;
         MD_SVC:  return 3'd2;
         MD_ABT:  return 3'd3;
         MD_IRQ:  return 3'd4;
         MD_UND:  return 3'd5;
         default: return BK_COMMON;
      endcase
   endfunction
endpackage

// File: rtl/mrf_phys_map.sv
module mrf_phys_map
   import mrf_pkg::*;
#(
   parameter int NUM_VIS    = 16,
   parameter int FIQ_FIRST  = 8,
   parameter int PRIV_FIRST = 13,
   parameter int VIS_AW     = 4,
   parameter int PHYS_AW    = 5
) (
   input  logic [MODE_W-1:0]  mode,
   input  logic [VIS_AW-1:0]  idx,
   output logic [PHYS_AW-1:0] phys
);
   localparam int FIQ_LO_N = PRIV_FIRST - FIQ_FIRST;
   localparam int PRIV_N   = NUM_VIS - 1 - PRIV_FIRST;

   int bank_i;
   int idx_i;
   int phys_i;

   always_comb begin
      bank_i = int'(bank_of(mode));
      idx_i  = int'(idx);
      phys_i = idx_i;
      if (bank_i == int'(BK_FIQ) && idx_i >= FIQ_FIRST && idx_i < PRIV_FIRST)
         phys_i = NUM_VIS + idx_i - FIQ_FIRST;
      else if (bank_i != int'(BK_COMMON) && idx_i >= PRIV_FIRST && idx_i < NUM_VIS - 1)
         phys_i = NUM_VIS + FIQ_LO_N + (bank_i - 1) * PRIV_N + idx_i - PRIV_FIRST;
      phys = PHYS_AW'(phys_i);
   end
endmodule

// File: rtl/mrf_storage.sv
module mrf_storage #(
   parameter int DATA_W  = 32,
   parameter int PHYS_N  = 31,
   parameter int PHYS_AW = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [PHYS_AW-1:0] waddr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [PHYS_AW-1:0] raddr_a,
   input  logic [PHYS_AW-1:0] raddr_b,
   output logic [DATA_W-1:0]  rdata_a,
   output logic [DATA_W-1:0]  rdata_b
);
   logic [DATA_W-1:0] regs_q [PHYS_N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < PHYS_N; k++) regs_q[k] <= '0;
      end else if (we && waddr < PHYS_AW'(PHYS_N)) begin
         regs_q[waddr] <= wdata;
      end
   end

   assign rdata_a = (raddr_a < PHYS_AW'(PHYS_N)) ? regs_q[raddr_a] : '0;
   assign rdata_b = (raddr_b < PHYS_AW'(PHYS_N)) ? regs_q[raddr_b] : '0;
endmodule

// File: rtl/mrf_status.sv
module mrf_status
   import mrf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] stat_wdata,
   input  logic              spsr_we,
   input  logic [DATA_W-1:0] spsr_wdata,
   input  logic              mode_req,
   input  logic [MODE_W-1:0] mode_tgt,
   output logic [MODE_W-1:0] cur_mode,
   output logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] spsr_rdata
);
   localparam int HI_W = DATA_W - MODE_W;
   localparam logic [HI_W-1:0] RST_HI =
      HI_W'((1 << (ST_IMASK - MODE_W)) | (1 << (ST_FMASK - MODE_W)));

   logic [HI_W-1:0]   hi_q;
   logic [MODE_W-1:0] mode_q;
   logic [DATA_W-1:0] slot_q [NUM_BANKS-1];
   logic [2:0]        bank_now;
   logic              accept;

   assign bank_now = bank_of(mode_q);
   assign accept   = mode_req && mode_ok(mode_tgt) && (mode_tgt != mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= RST_HI;
         mode_q <= MD_SVC;
         for (int k = 0; k < NUM_BANKS - 1; k++) slot_q[k] <= '0;
      end else begin
         if (stat_we) hi_q <= stat_wdata[DATA_W-1:MODE_W];
         if (accept)  mode_q <= mode_tgt;
         if (spsr_we && bank_now != BK_COMMON) slot_q[bank_now - 3'd1] <= spsr_wdata;
      end
   end

   assign cur_mode   = mode_q;
   assign status     = {hi_q, mode_q};
   assign spsr_rdata = (bank_now == BK_COMMON) ? '0 : slot_q[bank_now - 3'd1];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import mrf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_VIS    = 16,
   parameter int FIQ_FIRST  = 8,
   parameter int PRIV_FIRST = 13
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NUM_VIS)-1:0] rd_a_idx,
   output logic [DATA_W-1:0]          rd_a_data,
   input  logic [$clog2(NUM_VIS)-1:0] rd_b_idx,
   output logic [DATA_W-1:0]          rd_b_data,
   input  logic                       wr_en,
   input  logic [$clog2(NUM_VIS)-1:0] wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       stat_we,
   input  logic [DATA_W-1:0]          stat_wdata,
   input  logic                       spsr_we,
   input  logic [DATA_W-1:0]          spsr_wdata,
   output logic [DATA_W-1:0]          spsr_rdata,
   input  logic                       mode_req,
   input  logic [MODE_W-1:0]          mode_tgt,
   output logic [MODE_W-1:0]          cur_mode,
   output logic [DATA_W-1:0]          status
);
   localparam int VIS_AW   = $clog2(NUM_VIS);
   localparam int FIQ_LO_N = PRIV_FIRST - FIQ_FIRST;
   localparam int PRIV_N   = NUM_VIS - 1 - PRIV_FIRST;
   localparam int PHYS_N   = NUM_VIS + FIQ_LO_N + (NUM_BANKS - 1) * PRIV_N;
   localparam int PHYS_AW  = $clog2(PHYS_N + 1);
   localparam int N_PORTS  = 3;   // read A, read B, write

   if (DATA_W < ST_IMASK + 1) begin : g_bad_width
      $error("banked_regfile: DATA_W too small for status fields");
   end
   if (!(FIQ_FIRST < PRIV_FIRST && PRIV_FIRST < NUM_VIS - 1)) begin : g_bad_split
      $error("banked_regfile: bank split points out of order");
   end

   logic [VIS_AW-1:0]  port_idx  [N_PORTS];
   logic [PHYS_AW-1:0] port_phys [N_PORTS];

   assign port_idx[0] = rd_a_idx;
   assign port_idx[1] = rd_b_idx;
   assign port_idx[2] = wr_idx;

   for (genvar g = 0; g < N_PORTS; g++) begin : g_map
      mrf_phys_map #(
         .NUM_VIS   (NUM_VIS),
         .FIQ_FIRST (FIQ_FIRST),
         .PRIV_FIRST(PRIV_FIRST),
         .VIS_AW    (VIS_AW),
         .PHYS_AW   (PHYS_AW)
      ) u_map (
         .mode(cur_mode),
         .idx (port_idx[g]),
         .phys(port_phys[g])
      );
   end

   mrf_storage #(
      .DATA_W (DATA_W),
      .PHYS_N (PHYS_N),
      .PHYS_AW(PHYS_AW)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en),
      .waddr  (port_phys[2]),
      .wdata  (wr_data),
      .raddr_a(port_phys[0]),
      .raddr_b(port_phys[1]),
      .rdata_a(rd_a_data),
      .rdata_b(rd_b_data)
   );

   mrf_status #(
      .DATA_W(DATA_W)
   ) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_we   (stat_we),
      .stat_wdata(stat_wdata),
      .spsr_we   (spsr_we),
      .spsr_wdata(spsr_wdata),
      .mode_req  (mode_req),
      .mode_tgt  (mode_tgt),
      .cur_mode  (cur_mode),
      .status    (status),
      .spsr_rdata(spsr_rdata)
   );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
   import mrf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int VIS_AW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [VIS_AW-1:0] rd_a_idx,
   input logic [VIS_AW-1:0] rd_b_idx,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              stat_we,
   input logic              mode_req,
   input logic [MODE_W-1:0] mode_tgt,
   input logic [MODE_W-1:0] cur_mode,
   input logic [DATA_W-1:0] status,
   input logic [DATA_W-1:0] spsr_rdata
);
   a_r1_reset_mode: assert property (@(posedge clk)
      !rst_n |=> (cur_mode == MD_SVC && status[ST_IMASK] && status[ST_FMASK] && !status[ST_STATE]));

   a_r2_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));

   a_r8_user_spsr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MD_USR || cur_mode == MD_SYS) |-> (spsr_rdata == '0));

   a_r9_reject_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req && !mode_ok(mode_tgt)) |=> $stable(cur_mode));

   a_r10_mode_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req && mode_ok(mode_tgt)) |=> (cur_mode == $past(mode_tgt)));

   a_r11_mode_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_req |=> $stable(cur_mode));

   a_r11_hi_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_we |=> $stable(status[DATA_W-1:MODE_W]));
endmodule

bind banked_regfile banked_regfile_chk #(
   .DATA_W(DATA_W),
   .VIS_AW($clog2(NUM_VIS))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_a_idx  (rd_a_idx),
   .rd_b_idx  (rd_b_idx),
   .rd_a_data (rd_a_data),
   .rd_b_data (rd_b_data),
   .stat_we   (stat_we),
   .mode_req  (mode_req),
   .mode_tgt  (mode_tgt),
   .cur_mode  (cur_mode),
   .status    (status),
   .spsr_rdata(spsr_rdata)
);

// File: tb/banked_regfile_test.sv
`timescale 1ns/100ps
module banked_regfile_test;
   localparam logic [4:0] U = 5'b10000, F = 5'b10001, I = 5'b10010, V = 5'b10011,
                          A = 5'b10111, D = 5'b11011, S = 5'b11111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
   logic        wr_en = 1'b0, stat_we = 1'b0, spsr_we = 1'b0, mode_req = 1'b0;
   logic [31:0] stat_wdata = '0, spsr_wdata = '0, spsr_rdata, status;
   logic [4:0]  mode_tgt = '0, cur_mode;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   banked_regfile uut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .stat_we(stat_we), .stat_wdata(stat_wdata),
      .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
      .mode_req(mode_req), .mode_tgt(mode_tgt),
      .cur_mode(cur_mode), .status(status)
   );

   // swap-style reference model
   logic [31:0] m_live [16];
   logic [31:0] m_b13 [6];
   logic [31:0] m_b14 [6];
   logic [31:0] m_flo [5];
   logic [31:0] m_ulo [5];
   logic [31:0] m_slot [6];
   logic [31:0] m_spsr;
   logic [4:0]  m_mode;
   logic [26:0] m_hi;

   function automatic int bk(input logic [4:0] m);
      case (m)
         U, S: return 0;
         F: return 1;
         V: return 2;
         A: return 3;
         I: return 4;
         D: return 5;
         default: return -1;
      endcase
   endfunction

   task automatic m_reset();
      for (int k = 0; k < 16; k++) m_live[k] = '0;
      for (int k = 0; k < 6; k++) begin m_b13[k] = '0; m_b14[k] = '0; m_slot[k] = '0; end
      for (int k = 0; k < 5; k++) begin m_flo[k] = '0; m_ulo[k] = '0; end
      m_spsr = '0; m_mode = V; m_hi = 27'd6;
   endtask

   task automatic m_step();
      int f, t;
      if (!rst_n) begin m_reset(); return; end
      if (wr_en) m_live[wr_idx] = wr_data;
      if (spsr_we && bk(m_mode) > 0) m_spsr = spsr_wdata;
      if (stat_we) m_hi = stat_wdata[31:5];
      if (mode_req && bk(mode_tgt) >= 0 && mode_tgt != m_mode) begin
         f = bk(m_mode); t = bk(mode_tgt);
         m_b13[f] = m_live[13]; m_b14[f] = m_live[14];
         if (f > 0) m_slot[f] = m_spsr;
         if (f == 1) for (int k = 0; k < 5; k++) begin
            m_flo[k] = m_live[8+k]; m_live[8+k] = m_ulo[k];
         end
         if (t == 1) for (int k = 0; k < 5; k++) begin
            m_ulo[k] = m_live[8+k]; m_live[8+k] = m_flo[k];
         end
         m_live[13] = m_b13[t]; m_live[14] = m_b14[t];
         m_spsr = (t > 0) ? m_slot[t] : '0;
         m_mode = mode_tgt;
      end
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag);
      @(negedge clk); #0.5;
      chk(tag, "rd_a", rd_a_data, m_live[rd_a_idx]);
      chk(tag, "rd_b", rd_b_data, m_live[rd_b_idx]);
      chk(tag, "mode", {27'd0, cur_mode}, {27'd0, m_mode});
      chk(tag, "status", status, {m_hi, m_mode});
      chk(tag, "spsr", spsr_rdata, m_spsr);
      @(posedge clk); m_step(); #1;
   endtask

   task automatic sweep(input string tag);
      for (int k = 0; k < 8; k++) begin
         rd_a_idx = 4'(2*k); rd_b_idx = 4'(2*k+1); cyc(tag);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d, input string tag);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d; cyc(tag); wr_en = 1'b0;
   endtask

   task automatic chmode(input logic [4:0] m, input string tag);
      mode_req = 1'b1; mode_tgt = m; cyc(tag); mode_req = 1'b0;
   endtask

   task automatic spw(input logic [31:0] d, input string tag);
      spsr_we = 1'b1; spsr_wdata = d; cyc(tag); spsr_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [4:0] pick [8];
      pick[0] = U; pick[1] = F; pick[2] = I; pick[3] = V;
      pick[4] = A; pick[5] = D; pick[6] = S; pick[7] = 5'b10100;
      m_reset();
      // R1: reset state
      cyc("R1"); cyc("R1");
      rst_n = 1'b1;
      sweep("R1");
      // R2: write all, read back, read during write
      for (int k = 0; k < 16; k++) wr(k, 32'hA000_0000 | k, "R2");
      sweep("R2");
      rd_a_idx = 4'd3; rd_b_idx = 4'd3;
      wr(3, 32'h3333_0003, "R2");
      cyc("R2");
      // R6: user and system share 13/14
      chmode(U, "R6");
      wr(13, 32'hB000_0013, "R6"); wr(14, 32'hB000_0014, "R6");
      chmode(S, "R6"); sweep("R6");
      wr(14, 32'hB100_0014, "R6"); chmode(U, "R6"); sweep("R6");
      // R4: fast-interrupt bank 8..14
      chmode(F, "R4");
      for (int k = 8; k < 15; k++) wr(k, 32'hF000_0000 | k, "R4");
      sweep("R4");
      // R3: shared low registers visible in fast mode
      wr(2, 32'h2222_0002, "R3"); wr(15, 32'h1515_0015, "R3");
      chmode(U, "R4"); sweep("R4");
      chmode(F, "R4"); sweep("R4");
      // R5: other privileged modes bank 13/14 only
      chmode(I, "R5"); wr(13, 32'hC000_0013, "R5"); wr(9, 32'hC000_0009, "R5"); sweep("R5");
      chmode(A, "R5"); wr(14, 32'hD000_0014, "R5"); sweep("R5");
      chmode(D, "R5"); wr(13, 32'hE000_0013, "R5"); sweep("R5");
      chmode(I, "R5"); sweep("R5");
      // R7: saved status per mode
      spw(32'h1111_00AA, "R7");
      chmode(A, "R7"); spw(32'h2222_00BB, "R7");
      chmode(V, "R7"); cyc("R7");
      chmode(I, "R7"); cyc("R7");
      chmode(A, "R7"); cyc("R7");
      // R8: user/system saved status ignored
      chmode(U, "R8"); spw(32'hDEAD_BEEF, "R8"); cyc("R8");
      chmode(S, "R8"); spw(32'hFEED_F00D, "R8"); cyc("R8");
      chmode(A, "R8"); cyc("R8");
      // R9: invalid targets and same mode
      chmode(5'b00000, "R9"); chmode(5'b10100, "R9"); chmode(5'b11110, "R9");
      chmode(A, "R9"); sweep("R9");
      // R10: write in the same cycle as a change
      chmode(F, "R10");
      wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h9999_0009;
      spsr_we = 1'b1; spsr_wdata = 32'h5A5A_0001;
      mode_req = 1'b1; mode_tgt = U; cyc("R10");
      wr_en = 1'b0; spsr_we = 1'b0; mode_req = 1'b0;
      sweep("R10");
      wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h1313_0013;
      mode_req = 1'b1; mode_tgt = F; cyc("R10");
      wr_en = 1'b0; mode_req = 1'b0;
      sweep("R10");
      chmode(U, "R10"); sweep("R10");
      // R11: status write leaves mode alone
      stat_we = 1'b1; stat_wdata = 32'hFFFF_FFF1; cyc("R11");
      stat_wdata = 32'h0000_0020; cyc("R11"); stat_we = 1'b0;
      cyc("R11");
      // mixed pseudo-random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r;
         r = $urandom;
         rd_a_idx = r[3:0]; rd_b_idx = r[7:4];
         wr_en = r[8]; wr_idx = r[15:12]; wr_data = $urandom;
         spsr_we = r[9] & r[10]; spsr_wdata = $urandom;
         stat_we = (r[19:16] == 4'd0); stat_wdata = $urandom;
         mode_req = (r[21:20] == 2'd0); mode_tgt = pick[r[24:22]];
         cyc("R3");
      end
      wr_en = 1'b0; spsr_we = 1'b0; stat_we = 1'b0; mode_req = 1'b0;
      sweep("R3");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule